// File: doc/BRIEF.md
# Grouped External Interrupt Controller

This block gathers 25 external interrupt pins into four interrupt vectors. Each pin is synchronised to the system clock. It can then pass through a counting glitch filter. The filter runs on a sampling tick that all channels share, and each channel has its own acceptance length. After the filter, an edge detector can be set to watch rising edges, falling edges, or both. A detected edge sets a sticky per-channel flag.

A flag is routed to its vector only when that channel's interrupt enable is set. Channels 0-7, 8-15 and 16-23 each share one vector, and channel 24 has a vector to itself. No channel in a group has priority over another, so each vector is a plain OR.

Software uses a simple write port, sampled on the clock edge, and a combinational read port. Both take a 6-bit address.

| Address | Contents |
|---|---|
| 0 | Flags (write 1 to clear a flag) |
| 1 | Interrupt enables |
| 2 | Rising-edge enables |
| 3 | Falling-edge enables |
| 4 | Filter enables |
| 5 | Prescaler (4 bits) |
| 8 + c | Maximum count for channel c (4 bits) |

In every mask register, bit c belongs to channel c.

Top module: `ext_irq_grouper`

## Requirements
- R1: After reset, all flags, enables, the prescaler and `irq_vec` read as zero.
- R2: When only the rising enable of a channel is set, a low-to-high transition sets its flag, and a high-to-low transition leaves the flag clear.
- R3: When only the falling enable of a channel is set, a high-to-low transition sets its flag, and a low-to-high transition leaves the flag clear.
- R4: When both enables of a channel are set, either transition sets its flag.
- R5: With the filter off, a pad change made between clock edges shows in the flag register after exactly three rising clock edges, and not after two.
- R6: `irq_vec[v]` is the OR of (flag AND interrupt enable) over channels 8v to 8v+7, and channel 24 drives `irq_vec[3]` alone.
- R7: A flag whose interrupt enable is 0 still sets and still reads back, but it does not raise its vector.
- R8: Writing 1 to a bit at address 0 clears that flag. A 0 bit leaves its flag unchanged.
- R9: If an edge and a clear of the same flag fall in the same cycle, the flag stays set.
- R10: With the filter on and prescaler 0, a pad pulse lasting W clock cycles is accepted, and sets the flag, exactly when W >= maximum count.
- R11: With the filter on and a maximum count of 0, the input passes through with the same latency as with the filter off.
- R12: The sampling tick occurs once every (prescaler + 1) clocks, and the filter counts only on ticks. With prescaler 3 and maximum count 2, a 3-cycle pulse is rejected and a 12-cycle pulse is accepted.
- R13: A single transition sets the flag once. After the flag is cleared, it stays clear while the pad holds steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pad_in | input | 25 | External interrupt pins |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Write address |
| wr_data | input | 25 | Write data |
| rd_addr | input | 6 | Read address |
| rd_data | output | 25 | Read data (combinational) |
| irq_vec | output | 4 | Grouped interrupt vectors |

## Verification
Two things can act on the same flag in one cycle: a newly detected edge, and a write-1-to-clear from software. The bench first sets a flag on a channel with both edges enabled. It then drops the pad and times the clear write so that it is sampled on the same clock edge that registers the falling edge. The flag must read back as set. A clear issued alone, one write later, must then clear the flag.

// File: rtl/irq_grp_pkg.sv
package irq_grp_pkg;
  localparam int ADDR_W    = 6;
  localparam int MAXC_BASE = 8;

  localparam logic [ADDR_W-1:0] A_FLAG  = 6'd0;
  localparam logic [ADDR_W-1:0] A_IEN   = 6'd1;
  localparam logic [ADDR_W-1:0] A_RISE  = 6'd2;
  localparam logic [ADDR_W-1:0] A_FALL  = 6'd3;
  localparam logic [ADDR_W-1:0] A_FEN   = 6'd4;
  localparam logic [ADDR_W-1:0] A_PRESC = 6'd5;

  // number of vectors needed for n channels in groups of g
  function automatic int vec_count(int n, int g);
    return (n + g - 1) / g;
  endfunction

  function automatic int grp_lo(int v, int g);
    return v * g;
  endfunction

  function automatic int grp_hi(int v, int g, int n);
    return ((v + 1) * g < n) ? (v + 1) * g - 1 : n - 1;
  endfunction

  // true when one more sample reaches the acceptance length
  function automatic bit reach_limit(int cnt, int lim);
    return (cnt + 1) >= lim;
  endfunction

  function automatic logic [ADDR_W-1:0] maxc_addr(int c);
    return ADDR_W'(MAXC_BASE + c);
  endfunction
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int N      = 25,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] st [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) st[0] <= '0;
        else        st[0] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) st[s] <= '0;
        else        st[s] <= st[s-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/irq_prescaler.sv
module irq_prescaler #(
  parameter int PRE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PRE_W-1:0] div,
  output logic             tick,
  output logic [PRE_W-1:0] cnt
);
  assign tick = (cnt >= div);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
endmodule

// File: rtl/irq_glitch_filter.sv
module irq_glitch_filter
  import irq_grp_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             filt_en,
  input  logic [CNT_W-1:0] max_cnt,
  input  logic             din,
  output logic             dout
);
  logic             acc;
  logic [CNT_W-1:0] cnt;
  logic             bypass;

  assign bypass = !filt_en || (max_cnt == '0);
  assign dout   = bypass ? din : acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= 1'b0;
      cnt <= '0;
    end else if (bypass) begin
      acc <= din;
      cnt <= '0;
    end else if (tick) begin
      if (din != acc) begin
        if (reach_limit(int'(cnt), int'(max_cnt))) begin
          acc <= din;
          cnt <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        cnt <= '0;
      end
    end
  end
endmodule

// File: rtl/irq_edge_flag.sv
module irq_edge_flag #(
  parameter int N = 25
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  input  logic [N-1:0] rise_en,
  input  logic [N-1:0] fall_en,
  input  logic [N-1:0] clr,
  output logic [N-1:0] edge_evt,
  output logic [N-1:0] flags
);
  logic [N-1:0] prev;

  assign edge_evt = (lvl & ~prev & rise_en) | (~lvl & prev & fall_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev  <= '0;
      flags <= '0;
    end else begin
      prev  <= lvl;
      flags <= (flags & ~clr) | edge_evt;
    end
  end
endmodule

// File: rtl/ext_irq_grouper.sv
module ext_irq_grouper
  import irq_grp_pkg::*;
#(
  parameter int NUM_CH      = 25,
  parameter int GROUP_SIZE  = 8,
  parameter int CNT_W       = 4,
  parameter int PRE_W       = 4,
  parameter int SYNC_STAGES = 2,
  parameter int NUM_VEC     = vec_count(NUM_CH, GROUP_SIZE)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] pad_in,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [NUM_CH-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [NUM_CH-1:0] rd_data,
  output logic [NUM_VEC-1:0] irq_vec
);
  logic [NUM_CH-1:0] ien, rise_en, fall_en, fen;
  logic [PRE_W-1:0]  presc;
  logic [CNT_W-1:0]  max_cnt [NUM_CH];

  logic [NUM_CH-1:0] pad_sync, filt_lvl, edge_evt, flags, clr_mask;
  logic              tick;
  logic [PRE_W-1:0]  pre_cnt;

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien     <= '0;
      rise_en <= '0;
      fall_en <= '0;
      fen     <= '0;
      presc   <= '0;
    end else if (wr_en) begin
      if (wr_addr == A_IEN)   ien     <= wr_data;
      if (wr_addr == A_RISE)  rise_en <= wr_data;
      if (wr_addr == A_FALL)  fall_en <= wr_data;
      if (wr_addr == A_FEN)   fen     <= wr_data;
      if (wr_addr == A_PRESC) presc   <= wr_data[PRE_W-1:0];
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_maxc
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)
        max_cnt[c] <= '0;
      else if (wr_en && wr_addr == maxc_addr(c))
        max_cnt[c] <= wr_data[CNT_W-1:0];
  end

  assign clr_mask = (wr_en && wr_addr == A_FLAG) ? wr_data : '0;

  // read port
  always_comb begin
    rd_data = '0;
    if (rd_addr == A_FLAG)  rd_data = flags;
    if (rd_addr == A_IEN)   rd_data = ien;
    if (rd_addr == A_RISE)  rd_data = rise_en;
    if (rd_addr == A_FALL)  rd_data = fall_en;
    if (rd_addr == A_FEN)   rd_data = fen;
    if (rd_addr == A_PRESC) rd_data[PRE_W-1:0] = presc;
    for (int c = 0; c < NUM_CH; c++)
      if (rd_addr == maxc_addr(c)) rd_data[CNT_W-1:0] = max_cnt[c];
  end

  irq_sync #(.N(NUM_CH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pad_sync)
  );

  irq_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .div(presc), .tick(tick), .cnt(pre_cnt)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_filt
    irq_glitch_filter #(.CNT_W(CNT_W)) u_filt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .filt_en(fen[c]),
      .max_cnt(max_cnt[c]), .din(pad_sync[c]), .dout(filt_lvl[c])
    );
  end

  irq_edge_flag #(.N(NUM_CH)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(filt_lvl), .rise_en(rise_en),
    .fall_en(fall_en), .clr(clr_mask), .edge_evt(edge_evt), .flags(flags)
  );

  // vector combining, equal priority within a group
  for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
    localparam int LO = grp_lo(v, GROUP_SIZE);
    localparam int HI = grp_hi(v, GROUP_SIZE, NUM_CH);
    assign irq_vec[v] = |(flags[HI:LO] & ien[HI:LO]);
  end
endmodule

// File: rtl/irq_grp_chk.sv
module irq_grp_chk
  import irq_grp_pkg::*;
#(
  parameter int NUM_CH  = 25,
  parameter int NUM_VEC = 4,
  parameter int PRE_W   = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic [ADDR_W-1:0]  wr_addr,
  input logic [NUM_CH-1:0]  wr_data,
  input logic [NUM_CH-1:0]  edge_evt,
  input logic [NUM_CH-1:0]  flags,
  input logic [NUM_CH-1:0]  rise_en,
  input logic [NUM_CH-1:0]  fall_en,
  input logic [NUM_VEC-1:0] irq_vec,
  input logic               tick,
  input logic [PRE_W-1:0]   presc
);
  // R6
  vec_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_vec) |-> (|flags));

  // R9
  edge_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|edge_evt) |=> ((flags & $past(edge_evt)) == $past(edge_evt)));

  // R8
  clear_works_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_FLAG) |=>
      ((flags & $past(wr_data) & ~$past(edge_evt)) == '0));

  // R13
  flag_needs_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags & ~$past(flags) & ~$past(edge_evt)) == '0));

  // R2
  edge_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((edge_evt & ~(rise_en | fall_en)) == '0));

  // R12
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && presc != '0 && !(wr_en && wr_addr == A_PRESC)) |=> !tick);
endmodule

bind ext_irq_grouper irq_grp_chk #(
  .NUM_CH(NUM_CH), .NUM_VEC(NUM_VEC), .PRE_W(PRE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .edge_evt(edge_evt), .flags(flags),
  .rise_en(rise_en), .fall_en(fall_en), .irq_vec(irq_vec),
  .tick(tick), .presc(presc)
);

// File: tb/ext_irq_grouper_bench.sv
module ext_irq_grouper_bench;
  import irq_grp_pkg::*;

  localparam int NCH = 25;
  localparam int NV  = 4;
  localparam logic [NCH-1:0] ALL = {NCH{1'b1}};

  logic              clk = 1'b0;
  logic              rst_n;
  logic [NCH-1:0]    pad_in;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [NCH-1:0]    wr_data, rd_data;
  logic [NV-1:0]     irq_vec;

  int  n_chk = 0;
  int  n_err = 0;
  bit  done  = 0;

  always #10 clk = ~clk;

  ext_irq_grouper u_ext_irq_grouper (
    .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq_vec(irq_vec)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // called at a negedge; the write lands on the next rising edge
  task automatic wr(logic [ADDR_W-1:0] a, logic [NCH-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [ADDR_W-1:0] a, output logic [NCH-1:0] v);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  task automatic wait_edges(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [NCH-1:0] v;
    rst_n = 1'b0; pad_in = '0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_FLAG, v);  check("R1 flags", 32'(v), 0);
    rd(A_IEN, v);   check("R1 ien", 32'(v), 0);
    rd(A_PRESC, v); check("R1 presc", 32'(v), 0);
    check("R1 irq_vec", 32'(irq_vec), 0);

    // R5 / R6 sweep over every channel, rising edges, filter off
    wr(A_IEN, ALL);
    wr(A_RISE, ALL);
    for (int c = 0; c < NCH; c++) begin
      pad_in[c] = 1'b1;
      wait_edges(2);
      rd(A_FLAG, v); check("R5 not yet", 32'(v), 0);
      wait_edges(1);
      rd(A_FLAG, v); check("R5 flag", 32'(v), 32'(1) << c);
      check("R6 vector", 32'(irq_vec), 32'(1) << (c / 8));
      pad_in[c] = 1'b0;
      wr(A_FLAG, NCH'(1) << c);
      rd(A_FLAG, v); check("R8 cleared", 32'(v), 0);
    end

    // R7 masked channel
    wr(A_IEN, ALL & ~(NCH'(1) << 12));
    pad_in[12] = 1'b1;
    wait_edges(4);
    rd(A_FLAG, v); check("R7 flag set", 32'(v), 32'(1) << 12);
    check("R7 vector quiet", 32'(irq_vec), 0);
    pad_in[12] = 1'b0;
    wr(A_FLAG, ALL);
    wr(A_IEN, ALL);

    // R8 zero bits leave flags alone
    pad_in[1] = 1'b1;
    wait_edges(4);
    wr(A_FLAG, ALL & ~NCH'(2));
    rd(A_FLAG, v); check("R8 zero no effect", 32'(v), 2);
    pad_in[1] = 1'b0;
    wr(A_FLAG, NCH'(2));
    rd(A_FLAG, v); check("R8 one clears", 32'(v), 0);

    // R2 rising only
    wr(A_RISE, NCH'(1) << 2); wr(A_FALL, '0);
    pad_in[2] = 1'b1; wait_edges(4);
    rd(A_FLAG, v); check("R2 rise sets", 32'(v), 32'(1) << 2);
    wr(A_FLAG, ALL);
    pad_in[2] = 1'b0; wait_edges(5);
    rd(A_FLAG, v); check("R2 fall ignored", 32'(v), 0);

    // R3 falling only
    wr(A_RISE, '0); wr(A_FALL, NCH'(1) << 10);
    pad_in[10] = 1'b1; wait_edges(5);
    rd(A_FLAG, v); check("R3 rise ignored", 32'(v), 0);
    pad_in[10] = 1'b0; wait_edges(4);
    rd(A_FLAG, v); check("R3 fall sets", 32'(v), 32'(1) << 10);
    wr(A_FLAG, ALL);

    // R4 both edges
    wr(A_RISE, NCH'(1) << 17); wr(A_FALL, NCH'(1) << 17);
    pad_in[17] = 1'b1; wait_edges(4);
    rd(A_FLAG, v); check("R4 rise", 32'(v), 32'(1) << 17);
    wr(A_FLAG, ALL);
    pad_in[17] = 1'b0; wait_edges(4);
    rd(A_FLAG, v); check("R4 fall", 32'(v), 32'(1) << 17);
    wr(A_FLAG, ALL);

    // R9 edge and clear in the same cycle
    wr(A_RISE, NCH'(1) << 5); wr(A_FALL, NCH'(1) << 5);
    pad_in[5] = 1'b1; wait_edges(4);
    pad_in[5] = 1'b0;
    @(negedge clk); @(negedge clk);
    wr(A_FLAG, NCH'(1) << 5);
    rd(A_FLAG, v); check("R9 edge wins", 32'(v), 32'(1) << 5);
    wr(A_FLAG, NCH'(1) << 5);
    rd(A_FLAG, v); check("R9 later clear", 32'(v), 0);
    // R13 steady pad, flag stays clear
    wait_edges(10);
    rd(A_FLAG, v); check("R13 no repeat", 32'(v), 0);

    // R10 filter sweep, prescaler 0
    wr(A_RISE, NCH'(1) << 3); wr(A_FALL, '0); wr(A_FEN, NCH'(1) << 3);
    for (int m = 1; m <= 4; m++) begin
      wr(maxc_addr(3), NCH'(m));
      for (int w = 1; w <= 5; w++) begin
        pad_in[3] = 1'b1;
        repeat (w) @(negedge clk);
        pad_in[3] = 1'b0;
        repeat (12) @(negedge clk);
        rd(A_FLAG, v);
        check($sformatf("R10 m=%0d w=%0d", m, w), 32'(v),
              (w >= m) ? (32'(1) << 3) : 0);
        wr(A_FLAG, ALL);
      end
    end

    // R11 max count zero passes straight through
    wr(maxc_addr(3), '0);
    rd(maxc_addr(3), v); check("R11 readback", 32'(v), 0);
    pad_in[3] = 1'b1;
    wait_edges(2);
    rd(A_FLAG, v); check("R11 not yet", 32'(v), 0);
    wait_edges(1);
    rd(A_FLAG, v); check("R11 passthrough", 32'(v), 32'(1) << 3);
    pad_in[3] = 1'b0;
    wait_edges(3);
    wr(A_FLAG, ALL);

    // R12 prescaled sampling
    wr(A_PRESC, NCH'(3));
    wr(maxc_addr(3), NCH'(2));
    rd(A_PRESC, v); check("R12 presc readback", 32'(v), 3);
    pad_in[3] = 1'b1;
    repeat (3) @(negedge clk);
    pad_in[3] = 1'b0;
    repeat (30) @(negedge clk);
    rd(A_FLAG, v); check("R12 short rejected", 32'(v), 0);
    pad_in[3] = 1'b1;
    repeat (12) @(negedge clk);
    pad_in[3] = 1'b0;
    repeat (30) @(negedge clk);
    rd(A_FLAG, v); check("R12 long accepted", 32'(v), 32'(1) << 3);

    done = 1;
    summary();
    $finish;
  end
endmodule